// File: doc/BRIEF.md
# Programmable Asymmetric Reference Divider

This block turns a single-ended oscillator clock into a slow reference pulse train. It does not produce a square wave. Each output period has a high phase of exactly one oscillator cycle, followed by a low phase whose length is set by a 7-bit divide field N. The output period is therefore N + 2 oscillator cycles. A divide field of zero is reserved. The block handles it as N = 1, so the output keeps running.

A host programs two small control registers through a plain parallel write port. The first register holds the divide field and a source bit. The source bit picks what feeds the phase-detector reference: the divided pulse train, which lets a loop synthesize frequencies with no sync input present, or an external horizontal-sync input. The second register holds a 2-bit field that decides what drives a shared output pin: the divided reference or the lock indication. A change to the divide field is applied only when a new output period begins, so no runt pulse is ever produced.

Top module: `ref_divider_top`

## Requirements
- R1: The divided reference `ref_out` stays high for exactly one oscillator cycle in every period.
- R2: After each high cycle, `ref_out` stays low for N + 1 cycles, so the period is N + 2 cycles. This holds for every N from 1 (divide-by-3) to 127 (divide-by-129).
- R3: A divide field of 0 behaves exactly like N = 1, giving a low phase of 2 cycles.
- R4: A divide value written in the middle of a period does not change the low phase in progress. It is used from the next high pulse onward.
- R5: While `rst` is high, `ref_out`, `pd_ref_out` and `lockref_out` are 0. On the first clock edge after `rst` falls, `ref_out` goes high.
- R6: A write with `wr_addr`=0 loads the divide field N from `wr_data[6:0]` and the source bit from `wr_data[7]`. When the source bit is 1, `pd_ref_out` equals the value of `ref_out` one cycle earlier. When it is 0, `pd_ref_out` equals `hsync_in` one cycle earlier. After reset, N = 1 and the source bit is 0.
- R7: A write with `wr_addr`=1 loads the pin field from `wr_data[1:0]`. When the field is 2'b11, `lockref_out` equals `ref_out` one cycle earlier. For any other value, it equals `lock_in` one cycle earlier. After reset, the pin field is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register select: 0 = divide/source, 1 = pin field |
| wr_data | input | 8 | Write data |
| hsync_in | input | 1 | External horizontal-sync reference |
| lock_in | input | 1 | Lock indication from the loop |
| ref_out | output | 1 | Divided reference pulse train |
| pd_ref_out | output | 1 | Selected phase-detector reference |
| lockref_out | output | 1 | Shared lock/reference pin |

## Verification
The hardest case to reach from the ports is a divide write that lands inside a low phase already in progress. The bench aligns to a rising edge of `ref_out` and issues the write one cycle into the low phase. It then counts the remaining low cycles, which must still follow the old value, and measures the next period under the new value. The extreme settings N = 127 and the reserved N = 0 are reached through the vector table. Each entry is measured one full period after its write, so the old setting has drained by then.

// File: rtl/ref_div_pkg.sv
package ref_div_pkg;
  localparam int DIV_W  = 7;
  localparam int DATA_W = DIV_W + 1;
  localparam logic ADDR_DIV = 1'b0;
  localparam logic ADDR_PIN = 1'b1;
  localparam logic [1:0] PIN_SHOW_REF = 2'b11;
  localparam logic [DIV_W-1:0] DIV_RESET = DIV_W'(1);
endpackage

// File: rtl/ref_ctrl_regs.sv
module ref_ctrl_regs
  import ref_div_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DIV_W-1:0]  div_q,
  output logic              src_int_q,
  output logic [1:0]        pin_sel_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      div_q     <= DIV_RESET;
      src_int_q <= 1'b0;
      pin_sel_q <= 2'b00;
    end else if (wr_en) begin
      if (wr_addr == ADDR_DIV) begin
        div_q     <= wr_data[DIV_W-1:0];
        src_int_q <= wr_data[DATA_W-1];
      end else begin
        pin_sel_q <= wr_data[1:0];
      end
    end
  end

  // R6: a divide-register write shows up in the stored field
  a_r6_div_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_DIV) |=> (div_q == $past(wr_data[DIV_W-1:0])));
endmodule

// File: rtl/ref_pulse_gen.sv
module ref_pulse_gen #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  output logic             ref_q
);
  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] low_left_q;
  logic [DIV_W-1:0] div_eff;

  // reserved zero setting runs as the smallest legal divide
  assign div_eff = (div_i == '0) ? DIV_W'(1) : div_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q      <= 1'b0;
      low_left_q <= '0;
    end else if (low_left_q == '0) begin
      ref_q      <= 1'b1;
      low_left_q <= {1'b0, div_eff} + CNT_W'(1);
    end else begin
      ref_q      <= 1'b0;
      low_left_q <= low_left_q - CNT_W'(1);
    end
  end

  // R1: a high cycle is always followed by a low one
  a_r1_single_high: assert property (@(posedge clk) disable iff (rst)
    ref_q |=> !ref_q);
  // R2: a new pulse only starts once the low count has drained
  a_r2_pulse_at_zero: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_q) |-> ($past(low_left_q) == '0));
  // R5: first edge after reset release raises the output
  a_r5_first_pulse: assert property (@(posedge clk)
    $fell(rst) |=> ref_q);
endmodule

// File: rtl/ref_out_mux.sv
module ref_out_mux
  import ref_div_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_i,
  input  logic       hsync_i,
  input  logic       lock_i,
  input  logic       src_int_i,
  input  logic [1:0] pin_sel_i,
  output logic       pd_ref_q,
  output logic       pin_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pd_ref_q <= 1'b0;
      pin_q    <= 1'b0;
    end else begin
      pd_ref_q <= src_int_i ? ref_i : hsync_i;
      pin_q    <= (pin_sel_i == PIN_SHOW_REF) ? ref_i : lock_i;
    end
  end
endmodule

// File: rtl/ref_divider_top.sv
module ref_divider_top
  import ref_div_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hsync_in,
  input  logic              lock_in,
  output logic              ref_out,
  output logic              pd_ref_out,
  output logic              lockref_out
);
  logic [DIV_W-1:0] div_q;
  logic             src_int_q;
  logic [1:0]       pin_sel_q;

  ref_ctrl_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .div_q(div_q), .src_int_q(src_int_q), .pin_sel_q(pin_sel_q)
  );

  ref_pulse_gen #(.DIV_W(DIV_W)) u_gen (
    .clk(clk), .rst(rst), .div_i(div_q), .ref_q(ref_out)
  );

  ref_out_mux u_mux (
    .clk(clk), .rst(rst), .ref_i(ref_out), .hsync_i(hsync_in), .lock_i(lock_in),
    .src_int_i(src_int_q), .pin_sel_i(pin_sel_q),
    .pd_ref_q(pd_ref_out), .pin_q(lockref_out)
  );

  // R7: pin shows the divided reference when the field is 2'b11
  a_r7_pin_ref: assert property (@(posedge clk) disable iff (rst)
    (pin_sel_q == PIN_SHOW_REF) |=> (lockref_out == $past(ref_out)));
  // R6: internal source forwards the divided reference
  a_r6_pd_internal: assert property (@(posedge clk) disable iff (rst)
    src_int_q |=> (pd_ref_out == $past(ref_out)));
  // R5: reset holds every output low
  a_r5_reset_low: assert property (@(posedge clk)
    $past(rst) |-> (!ref_out && !pd_ref_out && !lockref_out));
endmodule

// File: tb/tb_ref_divider_top.sv
module tb_ref_divider_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       hsync_in = 1'b0;
  logic       lock_in = 1'b0;
  logic       ref_out, pd_ref_out, lockref_out;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  ref_divider_top dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync_in(hsync_in), .lock_in(lock_in),
    .ref_out(ref_out), .pd_ref_out(pd_ref_out), .lockref_out(lockref_out)
  );

  always #10 clk = ~clk;

  // {divide field, expected low length}
  localparam logic [14:0] VEC [6] = '{
    {7'd1, 8'd2}, {7'd2, 8'd3}, {7'd5, 8'd6},
    {7'd0, 8'd2}, {7'd64, 8'd65}, {7'd127, 8'd128}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic sync_rise();
    @(negedge clk);
    while (ref_out !== 1'b0) @(negedge clk);
    while (ref_out !== 1'b1) @(negedge clk);
  endtask

  task automatic measure(output int hi, output int lo);
    sync_rise();
    hi = 0; lo = 0;
    while (ref_out === 1'b1) begin hi++; @(negedge clk); end
    while (ref_out === 1'b0) begin lo++; @(negedge clk); end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int hi, lo;
    logic prev_ref, prev_in;
    repeat (3) @(negedge clk);
    // R5: reset state
    check("R5 ref_out in reset", int'(ref_out), 0);
    check("R5 pd_ref_out in reset", int'(pd_ref_out), 0);
    check("R5 lockref_out in reset", int'(lockref_out), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R5 first pulse after release", int'(ref_out), 1);
    // R2 default N=1 after reset
    measure(hi, lo);
    check("R2 reset default low", lo, 2);

    // R1 R2 R3 vector walk
    for (int i = 0; i < 6; i++) begin
      write_reg(1'b0, {1'b0, VEC[i][14:8]});
      measure(hi, lo);
      measure(hi, lo);
      check("R1 high time", hi, 1);
      check($sformatf("R2/R3 low time N=%0d", VEC[i][14:8]), lo, int'(VEC[i][7:0]));
    end

    // R4 mid-period write keeps the current low phase
    write_reg(1'b0, 8'd20);
    measure(hi, lo);
    sync_rise();
    @(negedge clk);
    lo = 1;
    wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'd1;
    @(negedge clk);
    wr_en = 1'b0;
    while (ref_out === 1'b0) begin lo++; @(negedge clk); end
    check("R4 low phase in progress", lo, 21);
    hi = 0;
    while (ref_out === 1'b1) begin hi++; @(negedge clk); end
    lo = 0;
    while (ref_out === 1'b0) begin lo++; @(negedge clk); end
    check("R4 next period uses new value", lo, 2);

    // R6 source from hsync (bit7=0) then from divider (bit7=1)
    write_reg(1'b0, 8'h03);
    prev_ref = ref_out; prev_in = hsync_in;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (k > 0) check("R6 hsync source", int'(pd_ref_out), int'(prev_in));
      hsync_in = (k % 3 == 0);
      prev_ref = ref_out; prev_in = hsync_in;
    end
    write_reg(1'b0, 8'h83);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (k > 0) check("R6 divider source", int'(pd_ref_out), int'(prev_ref));
      hsync_in = (k % 2 == 0);
      prev_ref = ref_out;
    end

    // R7 pin field 2'b10 shows lock, 2'b11 shows reference
    write_reg(1'b1, 8'h02);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (k > 0) check("R7 lock on pin", int'(lockref_out), int'(prev_in));
      lock_in = (k % 4 < 2);
      prev_in = lock_in;
    end
    write_reg(1'b1, 8'h03);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (k > 0) check("R7 reference on pin", int'(lockref_out), int'(prev_ref));
      lock_in = (k % 5 == 0);
      prev_ref = ref_out;
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule